// File: doc/BRIEF.md
# Masked Burst Write Sequencer

This block takes a burst-write instruction from a host over a shared 72-bit bus and stores a run of words into one of two on-chip arrays: a data array or a mask array. The host first loads an internal burst register with a start location and a length. It then issues the instruction: a command cycle, then an address cycle, then one data word per clock. Each word lands at the current burst location, and the location then advances by one.

Every word is merged bit by bit. Only the positions that are 1 in a selected global mask register take the new data, and every other bit of the stored word keeps its value. Completion is signalled on a three-state end-of-transfer line, modelled here as a value plus an output enable. The line is driven low while the burst is running, driven high for the last two cycles, and then released. The host may start the next instruction in the cycle after the release.

Top module: `burst_wr_seq`

## Requirements
- R1: After a synchronous active-low reset, `eot_oe`, `busy_seen`, `burst_addr` and `burst_len` are 0, and every array location and every global mask register reads as 0.
- R2: An instruction starts only when `cmd_valid` is 1 with `cmd[2:0]` equal to 3'b101 while the block is idle. Any other opcode leaves the outputs, the arrays and the burst register unchanged.
- R3: The global mask register used for the merge is number {`cmd[10]`, `cmd[5:3]`}, sampled in the command cycle. A stored word becomes (old AND NOT mask) OR (data AND mask).
- R4: In the address cycle, `dq[25:21]` must equal `dev_id` and `dq[20:19]` selects the target: 00 is the data array and 01 is the mask array. An ID mismatch, or a selector of 10 or 11, causes no write, keeps `eot_oe` at 0 and leaves `burst_addr` unchanged. The bits `dq[15:0]` have no effect.
- R5: The command cycle is cycle 1. Data words are taken in cycles 3 through n+1, where n is `burst_len`, and a length below 2 acts as 2. Word k goes to location start+k, which wraps modulo the array depth.
- R6: `eot_oe` is 1 from cycle 3 through cycle n+2 and 0 at all other times. `eot_o` is 0 in cycles 3 through n and 1 in cycles n+1 and n+2.
- R7: After a burst, `burst_addr` holds the last written location plus one, modulo the depth.
- R8: A write with `cfg_we` loads `burst_addr` from `cfg_addr` and `burst_len` from `cfg_len` only while the block is idle. During an instruction it has no effect.
- R9: A `cmd_valid` that arrives while an instruction is in progress is ignored, and it sets `busy_seen`. The flag stays set until reset.
- R10: A `gm_we` write loads global mask register `gm_idx` with `gm_data`. A new instruction can start in cycle n+3, directly after the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dev_id | input | 5 | This block's own device ID |
| cmd_valid | input | 1 | Command cycle strobe |
| cmd | input | 11 | Command word: opcode in [2:0], mask index in {10,5:3} |
| dq | input | 72 | Shared bus: address word, then data words |
| eot_o | output | 1 | End-of-transfer value |
| eot_oe | output | 1 | End-of-transfer drive enable |
| busy_seen | output | 1 | Sticky flag for a command rejected during an instruction |
| cfg_we | input | 1 | Load the burst register |
| cfg_addr | input | 4 | Burst start location |
| cfg_len | input | 4 | Burst length n |
| gm_we | input | 1 | Global mask register write strobe |
| gm_idx | input | 4 | Global mask register number |
| gm_data | input | 72 | Global mask register value |
| rd_sel | input | 1 | Read port array select (0 data, 1 mask) |
| rd_addr | input | 4 | Read port location |
| rd_data | output | 72 | Read port word, combinational |
| burst_addr | output | 4 | Current burst location |
| burst_len | output | 4 | Current burst length field |

## Verification
The end-of-transfer outputs are registered state, so the value for cycle k is set by the edge that ends cycle k-1. The bench samples `eot_o` and `eot_oe` at the falling edge inside cycle k and drives that cycle's bus word at the same moment. A data word given in cycle k is written at the edge that ends cycle k. The bench therefore compares array contents only after the burst has finished, through the combinational read port, one falling edge plus 1 ns after setting the read address. `burst_addr` and `busy_seen` are checked in the cycle after the release, when no further edge can change them.

// File: rtl/bws_pkg.sv
// Package: shared types and field positions for the masked burst write sequencer.
// Assumes the bus word is at least 26 bits wide so the address fields fit.
package bws_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ADDR = 2'd1,
        ST_DATA = 2'd2,
        ST_END  = 2'd3
    } seq_state_t;

    localparam logic [2:0] OP_BURST_WR = 3'b101;
    localparam int         ID_LSB      = 21;
    localparam int         ID_W        = 5;
    localparam int         SEL_LSB     = 19;
    localparam int         GIDX_W      = 4;
    localparam int         CMD_W       = 11;
endpackage

// File: rtl/bws_mask_bank.sv
// Module: bank of global mask registers with one write port and one read port.
// Assumes writes may happen at any time; the read is combinational.
module bws_mask_bank #(
    parameter int WORD_W = 72,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [IDX_W-1:0]  widx,
    input  logic [WORD_W-1:0] wdata,
    input  logic [IDX_W-1:0]  ridx,
    output logic [WORD_W-1:0] rmask
);
    localparam int NREG = 1 << IDX_W;

    logic [WORD_W-1:0] regs [NREG];

    // Purpose: clear all mask registers on reset, load one on a host write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs[i] <= '0;
        end else if (we) begin
            regs[widx] <= wdata;
        end
    end

    // Purpose: present the selected mask register.
    always_comb rmask = regs[ridx];
endmodule

// File: rtl/bws_store.sv
// Module: behavioural data and mask arrays with a bit-merged write port.
// Assumes at most one write per cycle; the read port is combinational.
module bws_store #(
    parameter int WORD_W = 72,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [WORD_W-1:0] wr_data,
    input  logic [WORD_W-1:0] wr_mask,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NBANK = 2;

    logic [WORD_W-1:0] bank_q [NBANK];

    for (genvar g = 0; g < NBANK; g++) begin : g_bank
        logic [WORD_W-1:0] mem [DEPTH];

        // Purpose: clear on reset, merge enabled bits of a write into one location.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                for (int a = 0; a < DEPTH; a++) mem[a] <= '0;
            end else if (wr_en && (wr_sel == 1'(g))) begin
                mem[wr_addr] <= (mem[wr_addr] & ~wr_mask) | (wr_data & wr_mask);
            end
        end

        assign bank_q[g] = mem[rd_addr];
    end

    // Purpose: pick the array named by the read select.
    always_comb rd_data = bank_q[rd_sel];

    a_r5_addr_known: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> !$isunknown({wr_addr, wr_sel}));
endmodule

// File: rtl/bws_ctrl.sv
// Module: instruction sequencer. It decodes the command, checks the address word,
// steps the burst location, raises write strobes and times the end-of-transfer line.
// Assumes the host holds each bus word for exactly one cycle.
module bws_ctrl
    import bws_pkg::*;
#(
    parameter int WORD_W = 72,
    parameter int ADDR_W = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ID_W-1:0]   dev_id,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd,
    input  logic [WORD_W-1:0] dq,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    output logic [GIDX_W-1:0] gidx,
    output logic              wr_en,
    output logic              wr_sel,
    output logic [ADDR_W-1:0] wr_addr,
    output logic              eot_o,
    output logic              eot_oe,
    output logic              busy_seen,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [LEN_W-1:0]  burst_len
);
    seq_state_t        state;
    logic [ADDR_W-1:0] addr_q;
    logic [LEN_W-1:0]  len_q;
    logic [LEN_W-1:0]  cnt;
    logic              sel_q;
    logic [GIDX_W-1:0] gidx_q;
    logic              busy_q;

    logic              cmd_hit;
    logic              target_ok;
    logic [1:0]        addr_sel;
    logic [LEN_W-1:0]  words_init;
    logic              unused_bits;

    assign unused_bits = ^{cmd[9:6], dq[WORD_W-1:ID_LSB+ID_W], dq[SEL_LSB-1:0]};

    // Purpose: decode the command and address word, derive the word count.
    always_comb begin
        cmd_hit    = cmd_valid && (cmd[2:0] == OP_BURST_WR);
        addr_sel   = dq[SEL_LSB +: 2];
        target_ok  = (dq[ID_LSB +: ID_W] == dev_id) && !addr_sel[1];
        words_init = (len_q < LEN_W'(2)) ? LEN_W'(1) : len_q - LEN_W'(1);
    end

    // Purpose: sequence state, burst register, word counter and latched selections.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            addr_q <= '0;
            len_q  <= '0;
            cnt    <= '0;
            sel_q  <= 1'b0;
            gidx_q <= '0;
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (cfg_we) begin
                        addr_q <= cfg_addr;
                        len_q  <= cfg_len;
                    end
                    if (cmd_hit) begin
                        gidx_q <= {cmd[10], cmd[5:3]};
                        state  <= ST_ADDR;
                    end
                end
                ST_ADDR: begin
                    if (target_ok) begin
                        sel_q <= addr_sel[0];
                        cnt   <= words_init;
                        state <= ST_DATA;
                    end else begin
                        state <= ST_IDLE;
                    end
                end
                ST_DATA: begin
                    addr_q <= addr_q + ADDR_W'(1);
                    cnt    <= cnt - LEN_W'(1);
                    if (cnt == LEN_W'(1)) state <= ST_END;
                end
                ST_END: state <= ST_IDLE;
                default: state <= ST_IDLE;
            endcase
        end
    end

    // Purpose: sticky record of a command arriving outside the idle state.
    always_ff @(posedge clk) begin
        if (!rst_n)                                busy_q <= 1'b0;
        else if (cmd_valid && (state != ST_IDLE)) busy_q <= 1'b1;
    end

    // Purpose: drive write strobes and the end-of-transfer pair from state.
    always_comb begin
        wr_en      = (state == ST_DATA);
        wr_sel     = sel_q;
        wr_addr    = addr_q;
        gidx       = gidx_q;
        eot_oe     = (state == ST_DATA) || (state == ST_END);
        eot_o      = (state == ST_END) || ((state == ST_DATA) && (cnt == LEN_W'(1)));
        busy_seen  = busy_q;
        burst_addr = addr_q;
        burst_len  = len_q;
    end

    a_r6_no_low_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_oe && eot_o) |=> !(eot_oe && !eot_o));
    a_r6_release_after_high: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(eot_oe) |-> $past(eot_o));
    a_r9_busy_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        busy_seen |=> busy_seen);
    a_r7_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !(cfg_we && (state == ST_IDLE))) |=> $stable(burst_addr));
    a_r8_cfg_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && (state != ST_IDLE)) |=> $stable(burst_len));
endmodule

// File: rtl/burst_wr_seq.sv
// Module: top of the masked burst write sequencer. It joins the sequencer,
// the global mask bank and the two arrays.
// Assumes a single device and a host that follows the cycle protocol.
module burst_wr_seq #(
    parameter int WORD_W = 72,
    parameter int ADDR_W = 4,
    parameter int LEN_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [4:0]        dev_id,
    input  logic              cmd_valid,
    input  logic [10:0]       cmd,
    input  logic [WORD_W-1:0] dq,
    output logic              eot_o,
    output logic              eot_oe,
    output logic              busy_seen,
    input  logic              cfg_we,
    input  logic [ADDR_W-1:0] cfg_addr,
    input  logic [LEN_W-1:0]  cfg_len,
    input  logic              gm_we,
    input  logic [3:0]        gm_idx,
    input  logic [WORD_W-1:0] gm_data,
    input  logic              rd_sel,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [WORD_W-1:0] rd_data,
    output logic [ADDR_W-1:0] burst_addr,
    output logic [LEN_W-1:0]  burst_len
);
    import bws_pkg::*;

    logic [GIDX_W-1:0] gidx;
    logic [WORD_W-1:0] sel_mask;
    logic              wr_en;
    logic              wr_sel;
    logic [ADDR_W-1:0] wr_addr;

    bws_ctrl #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .dev_id(dev_id),
        .cmd_valid(cmd_valid), .cmd(cmd), .dq(dq),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .gidx(gidx), .wr_en(wr_en), .wr_sel(wr_sel), .wr_addr(wr_addr),
        .eot_o(eot_o), .eot_oe(eot_oe), .busy_seen(busy_seen),
        .burst_addr(burst_addr), .burst_len(burst_len)
    );

    bws_mask_bank #(.WORD_W(WORD_W), .IDX_W(GIDX_W)) u_gmr (
        .clk(clk), .rst_n(rst_n), .we(gm_we), .widx(gm_idx),
        .wdata(gm_data), .ridx(gidx), .rmask(sel_mask)
    );

    bws_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel),
        .wr_addr(wr_addr), .wr_data(dq), .wr_mask(sel_mask),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data)
    );
endmodule

// File: tb/sim_burst_wr_seq.sv
module sim_burst_wr_seq;
    localparam logic [4:0] DEV = 5'd9;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [10:0] cmd = '0;
    logic [71:0] dq = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [3:0]  cfg_len = '0;
    logic        gm_we = 1'b0;
    logic [3:0]  gm_idx = '0;
    logic [71:0] gm_data = '0;
    logic        rd_sel = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        eot_o, eot_oe, busy_seen;
    logic [71:0] rd_data;
    logic [3:0]  burst_addr, burst_len;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [71:0] ref_arr [2][16];
    logic [71:0] ref_gm [16];
    logic [3:0]  ref_addr = '0;
    logic [3:0]  ref_len = '0;
    bit          ref_busy = 0;

    always #2 clk = ~clk;

    burst_wr_seq u0 (
        .clk(clk), .rst_n(rst_n), .dev_id(DEV), .cmd_valid(cmd_valid), .cmd(cmd),
        .dq(dq), .eot_o(eot_o), .eot_oe(eot_oe), .busy_seen(busy_seen),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_len(cfg_len),
        .gm_we(gm_we), .gm_idx(gm_idx), .gm_data(gm_data),
        .rd_sel(rd_sel), .rd_addr(rd_addr), .rd_data(rd_data),
        .burst_addr(burst_addr), .burst_len(burst_len)
    );

    task automatic check(input bit ok, input string tag, input logic [71:0] act, input logic [71:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [71:0] gen(input int k, input int seed);
        logic [31:0] a, b;
        a = 32'(seed) * 32'h9E3779B1 ^ 32'(k) * 32'h85EBCA6B;
        b = (a ^ 32'h5bd1e995) * 32'hC2B2AE35 + 32'(k);
        return {8'(seed + k * 3), a, b};
    endfunction

    task automatic check_arrays(input string tag);
        for (int s = 0; s < 2; s++) begin
            for (int a = 0; a < 16; a++) begin
                @(negedge clk);
                rd_sel = s[0];
                rd_addr = 4'(a);
                #1;
                check(rd_data === ref_arr[s][a], tag, rd_data, ref_arr[s][a]);
            end
        end
    endtask

    task automatic set_cfg(input int a, input int n);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 4'(a); cfg_len = 4'(n);
        @(negedge clk);
        cfg_we = 1'b0;
        ref_addr = 4'(a); ref_len = 4'(n);
    endtask

    // inj: 0 none, 1 stray command at cycle 3, 2 burst register write at cycle 3
    task automatic run_burst(input int gi, input int sel, input logic [4:0] id,
                             input int opc, input int inj, input int seed);
        int  n_eff;
        bit  active;
        logic [71:0] w;
        n_eff  = (ref_len < 2) ? 2 : int'(ref_len);
        active = (opc == 5) && (id == DEV) && (sel < 2);
        // cycle 1: block must be idle (R10: start directly after a release)
        @(negedge clk);
        check(eot_oe === 1'b0, "R10 idle before command", 72'(eot_oe), 72'(0));
        cmd_valid = 1'b1;
        cmd = '0;
        cmd[2:0] = 3'(opc);
        cmd[5:3] = 3'(gi);
        cmd[10] = gi[3];
        cmd[9:6] = 4'(seed);
        // cycle 2: address word, low 16 bits are noise (R4)
        @(negedge clk);
        check(eot_oe === 1'b0, "R6 not driven in cycle 2", 72'(eot_oe), 72'(0));
        cmd_valid = 1'b0;
        w = gen(99, seed);
        w[25:21] = id;
        w[20:19] = 2'(sel);
        dq = w;
        for (int k = 3; k <= n_eff + 2; k++) begin
            @(negedge clk);
            check(eot_oe === active, "R6 enable window", 72'(eot_oe), 72'(active));
            if (active)
                check(eot_o === (k >= n_eff + 1), "R6 value", 72'(eot_o), 72'(k >= n_eff + 1));
            if (k <= n_eff + 1) begin
                dq = gen(k, seed);
                if (active) begin
                    ref_arr[sel][ref_addr] = (ref_arr[sel][ref_addr] & ~ref_gm[gi]) |
                                             (dq & ref_gm[gi]);
                    ref_addr = ref_addr + 4'd1;
                end
            end else begin
                dq = gen(200, seed);
            end
            if (k == 3 && active && inj == 1) begin
                cmd_valid = 1'b1; cmd = 11'h005; ref_busy = 1;
            end
            if (k == 3 && active && inj == 2) begin
                cfg_we = 1'b1; cfg_addr = ref_addr ^ 4'hA; cfg_len = ~ref_len;
            end
            if (k == 4) begin
                cmd_valid = 1'b0; cfg_we = 1'b0;
            end
        end
        cmd_valid = 1'b0;
        cfg_we = 1'b0;
    endtask

    task automatic post_checks(input string tag);
        @(negedge clk);
        check(eot_oe === 1'b0, "R6 released after burst", 72'(eot_oe), 72'(0));
        check(burst_addr === ref_addr, {"R7 ", tag}, 72'(burst_addr), 72'(ref_addr));
        check(burst_len === ref_len, "R8 length kept", 72'(burst_len), 72'(ref_len));
        check(busy_seen === ref_busy, "R9 busy flag", 72'(busy_seen), 72'(ref_busy));
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < 2; s++)
            for (int a = 0; a < 16; a++) ref_arr[s][a] = '0;
        for (int i = 0; i < 16; i++) ref_gm[i] = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(eot_oe === 1'b0, "R1 eot_oe", 72'(eot_oe), 72'(0));
        check(busy_seen === 1'b0, "R1 busy", 72'(busy_seen), 72'(0));
        check(burst_addr === 4'd0, "R1 burst_addr", 72'(burst_addr), 72'(0));
        check(burst_len === 4'd0, "R1 burst_len", 72'(burst_len), 72'(0));
        rst_n = 1'b1;
        check_arrays("R1 arrays cleared");

        // R10: program mask registers; byte j is enabled when bit (j mod 4) of i is set
        for (int i = 0; i < 16; i++) begin
            logic [71:0] m;
            for (int j = 0; j < 9; j++) m[j*8 +: 8] = ((i >> (j % 4)) & 1) ? 8'hFF : 8'h00;
            if (i == 15) m = '1;
            if (i == 6) m = {36{2'b10}};
            @(negedge clk);
            gm_we = 1'b1; gm_idx = 4'(i); gm_data = m;
            ref_gm[i] = m;
        end
        @(negedge clk);
        gm_we = 1'b0;

        // R3 R5 R6 R7: sweep lengths 0..11, start points that wrap, both arrays
        for (int n = 0; n < 12; n++) begin
            set_cfg((n * 7 + 11) % 16, n);
            run_burst((n * 5 + 3) % 16, n % 2, DEV, 5, 0, n + 1);
            post_checks("sweep");
            check_arrays("R3 R5 sweep contents");
        end

        // R5: longest burst, wrapping
        set_cfg(10, 15);
        run_burst(15, 0, DEV, 5, 0, 77);
        post_checks("long wrap");
        check_arrays("R5 long burst contents");

        // R4: ID mismatch and reserved selectors
        run_burst(15, 0, DEV ^ 5'd1, 5, 0, 31);
        post_checks("id mismatch");
        run_burst(15, 2, DEV, 5, 0, 32);
        post_checks("selector 10");
        run_burst(15, 3, DEV, 5, 0, 33);
        post_checks("selector 11");
        check_arrays("R4 no write when not targeted");

        // R2: other opcodes do nothing
        run_burst(15, 0, DEV, 3, 0, 41);
        post_checks("bad opcode 3");
        run_burst(15, 1, DEV, 4, 0, 42);
        post_checks("bad opcode 4");
        check_arrays("R2 arrays unchanged");

        // R8: burst register write during a burst is ignored
        set_cfg(3, 6);
        run_burst(6, 1, DEV, 5, 2, 51);
        post_checks("cfg during burst");

        // R9 R10: stray command mid-burst, then back-to-back bursts with no gap
        run_burst(9, 0, DEV, 5, 1, 61);
        run_burst(12, 1, DEV, 5, 0, 62);
        run_burst(5, 0, DEV, 5, 0, 63);
        post_checks("back to back");
        check_arrays("R9 R10 contents after stray command");

        // R9: flag stays set across a further burst
        set_cfg(0, 2);
        run_burst(1, 0, DEV, 5, 0, 71);
        post_checks("busy sticky");
        check_arrays("R3 R5 minimum length");

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule